// File: doc/BRIEF.md
# Radio packet framer and serializer

This block turns a short packet held in a byte buffer into the synchronous bit stream that keys a radio transmitter. After a start strobe it drives the active-low transmitter enable and sends a square-wave preamble to let the remote data slicer settle. A fixed frame-sync byte follows. Each packet byte then goes out as a DC-balanced 12-bit symbol, and the packet ends with a symbol that carries an 8-bit checksum. The line stays low whenever the transmitter is off.

A remote receiver may be asleep and only wake for short listening windows. For that case the caller can ask for an extended wake-up preamble. It is a run of preamble blocks, and each block ends with a complemented sync code that tells the receiver to stay awake. The packet length comes from the low bits of the first (control) byte. A one-clock done strobe marks the end of the frame.

Top module: `rf_tx_framer`

## Requirements
- R1: Out of reset and whenever no frame is in progress, `tx_en_n` is 1, `done` is 0 and `txd` is 0. `txd` is 0 on every cycle in which `tx_en_n` is 1.
- R2: Each transmitted bit lasts exactly `BIT_DIV` clocks. The first bit appears on `txd`, with `tx_en_n` at 0, on the clock edge that samples `start` high.
- R3: The normal preamble is `pre_cycles` repetitions of the bit pair 0 then 1. A `pre_cycles` value of 0 behaves as 1.
- R4: The preamble is followed by the sync byte 1110_0100, sent most significant bit first.
- R5: Byte value b is sent as the b-th code, counting from 0, in ascending numeric order among all 12-bit codes that hold exactly six ones and have no run of more than four equal bits. The code is sent most significant bit first.
- R6: The byte at buffer address 0 is the control byte. Its bits [4:0] give N, the number of bytes that follow it, and any N above 26 is taken as 26. Bytes 0 to N are sent in address order. `rd_data` may lag `rd_addr` by one clock.
- R7: After the last byte, the block sends the symbol of the sum modulo 256 of every byte it sent, control byte included.
- R8: If `wake_req` is 1 and `wake_units` is not 0 at start, the normal preamble is preceded by `wake_units` blocks. Each block is `HOLD_PERIOD` preamble pairs followed by the hold code 0001_1011. Otherwise no block is sent.
- R9: On the clock edge that ends the last checksum bit, `done` goes to 1 for exactly one clock. On that same edge `tx_en_n` returns to 1.
- R10: A `start` pulse during a frame is ignored. Configuration inputs are captured only when a frame starts, so changing them during a frame alters neither the bit stream nor its end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-clock request to send the buffered packet |
| pre_cycles | input | 8 | Number of preamble pairs |
| wake_units | input | 8 | Number of wake-up blocks |
| wake_req | input | 1 | Request an extended wake-up preamble |
| rd_addr | output | 5 | Packet buffer read address |
| rd_data | input | 8 | Packet buffer read data |
| tx_en_n | output | 1 | Transmitter enable, active low |
| txd | output | 1 | Serial data to the transmitter |
| done | output | 1 | One-clock end-of-frame strobe |

## Verification
Some properties are checked by assertions on every clock cycle:
- the line is low while the transmitter is off;
- `txd` changes only at a bit boundary or at a frame start;
- the bit timer never ticks twice in a row;
- every symbol loaded from the table is balanced;
- the done strobe is a single cycle that coincides with the enable being released;
- the read address stays inside the buffer.

Other behaviour only the directed scenarios can show: the exact order and content of the preamble, sync, wake-up blocks, symbols and checksum, the clipping of the length field, and that a start pulse or configuration change during a frame leaves the stream untouched. Each scenario compares the sampled line against a stream built from the requirements.

// File: rtl/rf_tx_pkg.sv
package rf_tx_pkg;

  localparam int SYM_W    = 12;
  localparam int BYTE_W   = 8;
  localparam int SYM_CNT  = 256;
  localparam int ROM_BITS = SYM_CNT * SYM_W;

  localparam logic [BYTE_W-1:0] SYNC_CODE = 8'b1110_0100;
  localparam logic [BYTE_W-1:0] HOLD_CODE = ~SYNC_CODE;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WAKE,
    PH_HOLD,
    PH_PRE,
    PH_SYNC,
    PH_DATA,
    PH_SUM
  } phase_t;

  // Collects, in ascending order, the first 256 twelve-bit codes with six
  // ones and no run longer than four. Two nested 64-step loops keep each
  // loop short during constant evaluation.
  function automatic logic [ROM_BITS-1:0] build_sym_rom();
    logic [ROM_BITS-1:0] tbl;
    logic [SYM_W-1:0]    code;
    int found;
    int ones;
    int run;
    int worst;
    tbl   = '0;
    found = 0;
    for (int hi = 0; hi < 64; hi++) begin
      for (int lo = 0; lo < 64; lo++) begin
        code  = SYM_W'(hi * 64 + lo);
        ones  = 0;
        run   = 1;
        worst = 1;
        for (int b = 0; b < SYM_W; b++) begin
          ones = ones + int'(code[b]);
          if (b > 0) begin
            if (code[b] == code[b-1]) run = run + 1;
            else                      run = 1;
            if (run > worst) worst = run;
          end
        end
        if (ones == 6 && worst <= 4 && found < SYM_CNT) begin
          tbl[found*SYM_W +: SYM_W] = code;
          found = found + 1;
        end
      end
    end
    return tbl;
  endfunction

endpackage

// File: rtl/rf_bit_timer.sv
module rf_bit_timer #(
  parameter int BIT_DIV = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);

  localparam int CW = (BIT_DIV > 1) ? $clog2(BIT_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(BIT_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)             cnt_d = '0;
    else if (run) begin
      if (cnt_q == LAST) cnt_d = '0;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run && (cnt_q == LAST);

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/rf_sym_rom.sv
module rf_sym_rom
  import rf_tx_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_in,
  output logic [SYM_W-1:0]  sym_out
);

  localparam logic [ROM_BITS-1:0] TABLE = build_sym_rom();

  assign sym_out = TABLE[int'(byte_in) * SYM_W +: SYM_W];

endmodule

// File: rtl/rf_frame_seq.sv
module rf_frame_seq
  import rf_tx_pkg::*;
#(
  parameter int HOLD_PERIOD = 256,
  parameter int MAX_BYTES   = 27,
  parameter int ADDR_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        pre_cycles,
  input  logic [7:0]        wake_units,
  input  logic              wake_req,
  input  logic              tick,
  output logic              busy,
  output logic              accept,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rom_idx,
  input  logic [SYM_W-1:0]  rom_sym,
  output logic              tx_en_n,
  output logic              txd,
  output logic              done
);

  localparam int CYC_W = ($clog2(HOLD_PERIOD) > 8) ? $clog2(HOLD_PERIOD) : 8;
  localparam logic [CYC_W-1:0]  HOLD_LAST = CYC_W'(HOLD_PERIOD - 1);
  localparam logic [ADDR_W-1:0] LAST_MAX  = ADDR_W'(MAX_BYTES - 1);
  localparam logic [SYM_W-1:0]  PRE_PAT   = {2'b01, {(SYM_W-2){1'b0}}};
  localparam logic [SYM_W-1:0]  SYNC_PAT  = {SYNC_CODE, {(SYM_W-BYTE_W){1'b0}}};
  localparam logic [SYM_W-1:0]  HOLD_PAT  = {HOLD_CODE, {(SYM_W-BYTE_W){1'b0}}};

  phase_t              phase_q, phase_d;
  logic [SYM_W-1:0]    sh_q, sh_d;
  logic [3:0]          nleft_q, nleft_d;
  logic                txd_q, txd_d;
  logic                en_n_q, en_n_d;
  logic                done_q, done_d;
  logic [CYC_W-1:0]    cyc_q, cyc_d;
  logic [7:0]          unit_q, unit_d;
  logic [7:0]          pre_q, pre_d;
  logic [7:0]          wun_q, wun_d;
  logic [ADDR_W-1:0]   idx_q, idx_d;
  logic [ADDR_W-1:0]   last_q, last_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [BYTE_W-1:0]   sum_q, sum_d;

  logic                load;
  logic [SYM_W-1:0]    pat;
  logic [3:0]          plen;
  logic [ADDR_W-1:0]   len_field;
  logic                at_last;

  assign busy      = (phase_q != PH_IDLE);
  assign accept    = start && !busy;
  assign at_last   = (idx_q == last_q);
  assign rom_idx   = (phase_q == PH_DATA && at_last) ? sum_q : rd_data;
  assign len_field = rd_data[ADDR_W-1:0];

  always_comb begin
    phase_d = phase_q;
    sh_d    = sh_q;
    nleft_d = nleft_q;
    txd_d   = txd_q;
    en_n_d  = en_n_q;
    done_d  = 1'b0;
    cyc_d   = cyc_q;
    unit_d  = unit_q;
    pre_d   = pre_q;
    wun_d   = wun_q;
    idx_d   = idx_q;
    last_d  = last_q;
    addr_d  = addr_q;
    sum_d   = sum_q;
    load    = 1'b0;
    pat     = PRE_PAT;
    plen    = 4'd2;

    if (accept) begin
      pre_d   = (pre_cycles == 8'd0) ? 8'd1 : pre_cycles;
      wun_d   = wake_units;
      unit_d  = '0;
      cyc_d   = '0;
      addr_d  = '0;
      idx_d   = '0;
      sum_d   = '0;
      en_n_d  = 1'b0;
      phase_d = (wake_req && wake_units != 8'd0) ? PH_WAKE : PH_PRE;
      load    = 1'b1;
    end else if (tick && busy) begin
      if (nleft_q != 4'd0) begin
        txd_d   = sh_q[SYM_W-1];
        sh_d    = sh_q << 1;
        nleft_d = nleft_q - 4'd1;
      end else begin
        case (phase_q)
          PH_WAKE: begin
            load = 1'b1;
            if (cyc_q == HOLD_LAST) begin
              phase_d = PH_HOLD;
              cyc_d   = '0;
              pat     = HOLD_PAT;
              plen    = 4'd8;
            end else begin
              cyc_d = cyc_q + 1'b1;
            end
          end
          PH_HOLD: begin
            load = 1'b1;
            if (unit_q == wun_q - 8'd1) begin
              phase_d = PH_PRE;
            end else begin
              unit_d  = unit_q + 8'd1;
              phase_d = PH_WAKE;
            end
          end
          PH_PRE: begin
            load = 1'b1;
            if (cyc_q + 1'b1 == CYC_W'(pre_q)) begin
              phase_d = PH_SYNC;
              pat     = SYNC_PAT;
              plen    = 4'd8;
            end else begin
              cyc_d = cyc_q + 1'b1;
            end
          end
          PH_SYNC: begin
            load    = 1'b1;
            pat     = rom_sym;
            plen    = 4'd12;
            phase_d = PH_DATA;
            last_d  = (len_field > LAST_MAX) ? LAST_MAX : len_field;
            sum_d   = rd_data;
            idx_d   = '0;
            addr_d  = ADDR_W'(1);
          end
          PH_DATA: begin
            load = 1'b1;
            pat  = rom_sym;
            plen = 4'd12;
            if (at_last) begin
              phase_d = PH_SUM;
            end else begin
              idx_d  = idx_q + 1'b1;
              addr_d = addr_q + 1'b1;
              sum_d  = sum_q + rd_data;
            end
          end
          PH_SUM: begin
            phase_d = PH_IDLE;
            en_n_d  = 1'b1;
            txd_d   = 1'b0;
            done_d  = 1'b1;
          end
          default: ;
        endcase
      end
    end

    if (load) begin
      txd_d   = pat[SYM_W-1];
      sh_d    = pat << 1;
      nleft_d = plen - 4'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      sh_q    <= '0;
      nleft_q <= '0;
      txd_q   <= 1'b0;
      en_n_q  <= 1'b1;
      done_q  <= 1'b0;
      cyc_q   <= '0;
      unit_q  <= '0;
      pre_q   <= '0;
      wun_q   <= '0;
      idx_q   <= '0;
      last_q  <= '0;
      addr_q  <= '0;
      sum_q   <= '0;
    end else begin
      phase_q <= phase_d;
      sh_q    <= sh_d;
      nleft_q <= nleft_d;
      txd_q   <= txd_d;
      en_n_q  <= en_n_d;
      done_q  <= done_d;
      cyc_q   <= cyc_d;
      unit_q  <= unit_d;
      pre_q   <= pre_d;
      wun_q   <= wun_d;
      idx_q   <= idx_d;
      last_q  <= last_d;
      addr_q  <= addr_d;
      sum_q   <= sum_d;
    end
  end

  assign rd_addr = addr_q;
  assign tx_en_n = en_n_q;
  assign txd     = txd_q;
  assign done    = done_q;

  // R1
  idle_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_n_q |-> !txd_q);

  // R2
  txd_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd_q) |-> $past(tick || accept));

  // R5
  sym_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && nleft_q == 4'd0 && (phase_q == PH_SYNC || phase_q == PH_DATA))
      |-> ($countones(rom_sym) == 6));

  // R6
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (addr_q <= ADDR_W'(MAX_BYTES)));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R9
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (en_n_q && $past(!en_n_q)));

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !tick) |=> $stable(txd_q));

endmodule

// File: rtl/rf_tx_framer.sv
module rf_tx_framer
  import rf_tx_pkg::*;
#(
  parameter int BIT_DIV     = 256,
  parameter int HOLD_PERIOD = 256,
  parameter int MAX_BYTES   = 27
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] pre_cycles,
  input  logic [7:0] wake_units,
  input  logic       wake_req,
  output logic [4:0] rd_addr,
  input  logic [7:0] rd_data,
  output logic       tx_en_n,
  output logic       txd,
  output logic       done
);

  localparam int ADDR_W = 5;

  logic              tick;
  logic              busy;
  logic              accept;
  logic [BYTE_W-1:0] rom_idx;
  logic [SYM_W-1:0]  rom_sym;

  rf_bit_timer #(.BIT_DIV(BIT_DIV)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .run   (busy),
    .tick  (tick)
  );

  rf_sym_rom u_rom (
    .byte_in (rom_idx),
    .sym_out (rom_sym)
  );

  rf_frame_seq #(
    .HOLD_PERIOD (HOLD_PERIOD),
    .MAX_BYTES   (MAX_BYTES),
    .ADDR_W      (ADDR_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .pre_cycles (pre_cycles),
    .wake_units (wake_units),
    .wake_req   (wake_req),
    .tick       (tick),
    .busy       (busy),
    .accept     (accept),
    .rd_data    (rd_data),
    .rd_addr    (rd_addr),
    .rom_idx    (rom_idx),
    .rom_sym    (rom_sym),
    .tx_en_n    (tx_en_n),
    .txd        (txd),
    .done       (done)
  );

endmodule

// File: tb/tb_rf_tx_framer.sv
module tb_rf_tx_framer;

  localparam int D  = 4;
  localparam int HP = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [7:0] pre_cycles;
  logic [7:0] wake_units;
  logic       wake_req;
  logic [4:0] rd_addr;
  logic [7:0] rd_data;
  logic       tx_en_n;
  logic       txd;
  logic       done;

  logic [7:0]  mem [32];
  logic [11:0] sym_tbl [256];
  bit          exp_q [$];
  int          total = 0;
  int          bad   = 0;

  always #5 clk = ~clk;

  always_ff @(posedge clk) rd_data <= mem[rd_addr];

  rf_tx_framer #(.BIT_DIV(D), .HOLD_PERIOD(HP)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pre_cycles(pre_cycles),
    .wake_units(wake_units), .wake_req(wake_req), .rd_addr(rd_addr),
    .rd_data(rd_data), .tx_en_n(tx_en_n), .txd(txd), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int longest_run(input logic [11:0] v);
    int best = 1;
    int cur  = 1;
    for (int i = 1; i < 12; i++) begin
      cur  = (v[i] == v[i-1]) ? cur + 1 : 1;
      best = (cur > best) ? cur : best;
    end
    return best;
  endfunction

  task automatic push_bits(input logic [11:0] v, input int len);
    for (int i = len - 1; i >= 0; i--) exp_q.push_back(v[i]);
  endtask

  task automatic build_expected(input int pre, input int wu, input bit wreq);
    int         n;
    logic [7:0] sum;
    exp_q.delete();
    if (wreq && wu != 0)
      for (int u = 0; u < wu; u++) begin
        for (int c = 0; c < HP; c++) push_bits(12'h001, 2);
        push_bits(12'h01B, 8);
      end
    for (int c = 0; c < ((pre == 0) ? 1 : pre); c++) push_bits(12'h001, 2);
    push_bits(12'h0E4, 8);
    n   = int'(mem[0][4:0]);
    n   = (n > 26) ? 26 : n;
    sum = 8'h00;
    for (int i = 0; i <= n; i++) begin
      push_bits(sym_tbl[mem[i]], 12);
      sum = sum + mem[i];
    end
    push_bits(sym_tbl[sum], 12);
  endtask

  task automatic run_frame(input string req, input int pre, input int wu,
                           input bit wreq, input bit poke);
    int mism  = 0;
    int first = -1;
    int fact  = 0;
    build_expected(pre, wu, wreq);
    @(negedge clk);
    pre_cycles = 8'(pre);
    wake_units = 8'(wu);
    wake_req   = wreq;
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < exp_q.size(); k++) begin
      repeat (D / 2) @(negedge clk);
      if (txd !== exp_q[k] || tx_en_n !== 1'b0 || done !== 1'b0) begin
        if (first < 0) begin
          first = k;
          fact  = {tx_en_n, done, txd};
        end
        mism++;
      end
      if (poke && k == 5) begin
        start      = 1'b1;
        pre_cycles = 8'd9;
        wake_units = 8'd5;
        wake_req   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (D - D / 2 - 1) @(negedge clk);
      end else begin
        repeat (D - D / 2) @(negedge clk);
      end
    end
    if (mism != 0)
      $display("FAIL %s stream bit %0d of %0d: {en_n,done,txd} actual=%0h expected=%0h",
               req, first, exp_q.size(), fact, int'(exp_q[first]));
    check(mism == 0, {req, " stream"}, mism, 0);
    check(done === 1'b1 && tx_en_n === 1'b1 && txd === 1'b0,
          "R9 end edge", {tx_en_n, done, txd}, 3'b110);
    @(negedge clk);
    check(done === 1'b0, "R9 done one clock", done, 0);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(tx_en_n === 1'b1 && txd === 1'b0 && done === 1'b0,
            "R1 idle outputs", {tx_en_n, done, txd}, 3'b100);
    end
  endtask

  task automatic t_single();
    mem[0] = 8'h00;
    run_frame("R2 R3 R4 R5 R7 single byte", 3, 0, 1'b0, 1'b0);
  endtask

  task automatic t_multi();
    mem[0] = 8'h04; mem[1] = 8'h5A; mem[2] = 8'hFF; mem[3] = 8'h00; mem[4] = 8'h81;
    run_frame("R5 R7 five bytes", 2, 0, 1'b0, 1'b0);
  endtask

  task automatic t_full();
    mem[0] = 8'h1A;
    for (int i = 1; i < 32; i++) mem[i] = 8'(i * 37 + 200);
    run_frame("R6 R7 full length", 2, 0, 1'b0, 1'b0);
  endtask

  task automatic t_clip();
    mem[0] = 8'h1F;
    run_frame("R6 length clipped", 1, 0, 1'b0, 1'b0);
  endtask

  task automatic t_pre_zero();
    mem[0] = 8'h01; mem[1] = 8'hC3;
    run_frame("R3 zero preamble", 0, 0, 1'b0, 1'b0);
  endtask

  task automatic t_wake();
    mem[0] = 8'h02; mem[1] = 8'h11; mem[2] = 8'hEE;
    run_frame("R8 two wake blocks", 2, 2, 1'b1, 1'b0);
    run_frame("R8 wake count zero", 2, 0, 1'b1, 1'b0);
    run_frame("R8 wake not requested", 2, 3, 1'b0, 1'b0);
  endtask

  task automatic t_busy();
    int extra = 0;
    mem[0] = 8'h03; mem[1] = 8'h7E; mem[2] = 8'h18; mem[3] = 8'hA5;
    run_frame("R10 start while busy", 3, 0, 1'b0, 1'b1);
    for (int i = 0; i < 3 * D; i++) begin
      @(negedge clk);
      if (tx_en_n !== 1'b1 || done !== 1'b0) extra++;
    end
    check(extra == 0, "R10 no second frame", extra, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n = 0;
    for (int c = 0; c < 4096 && n < 256; c++) begin
      logic [11:0] v;
      v = 12'(c);
      if ($countones(v) == 6 && longest_run(v) <= 4) begin
        sym_tbl[n] = v;
        n++;
      end
    end
    for (int i = 0; i < 32; i++) mem[i] = 8'h00;
    rst_n      = 1'b0;
    start      = 1'b0;
    pre_cycles = 8'd0;
    wake_units = 8'd0;
    wake_req   = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_multi();
    t_full();
    t_clip();
    t_pre_zero();
    t_wake();
    t_busy();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule